// File: doc/BRIEF.md
# SMBus Indexed Block Register Slave

This block is a two-wire bus target that serves a small file of byte-wide configuration registers. A host reaches the file through indexed block transfers. For a write, the host addresses the device, supplies a starting index, then a byte count, then streams data. The slave stores the bytes at consecutive indices and honours only as many as the count allows. For a read, the host addresses the device for writing, supplies the starting index, issues a repeated start and readdresses the device for reading. The slave then returns the contents of a dedicated count register, followed by data from the index upward, until the host declines a byte.

The block runs entirely on a system clock that oversamples SCL and SDA through a synchronizer. It detects edges, start and stop conditions in that clock domain. It drives SDA in open-drain fashion through an enable that pulls the line low. The complete register file is presented as one parallel bus for the configuration logic around it. The index persists between transactions.

The controller states are IDLE, ADDR, ADDR_ACK, INDEX, INDEX_ACK, COUNT, COUNT_ACK, WDATA, WDATA_ACK, TX, TX_ACK, TX_HOLD and IGNORE.

- A stop moves any state to IDLE. A start, including a repeated start, moves any state to ADDR.
- The byte-collecting states (ADDR, INDEX, COUNT, WDATA) leave at the falling SCL edge after the eighth bit:
  - ADDR goes to ADDR_ACK on a matching address and to IGNORE on any other.
  - INDEX goes to INDEX_ACK, COUNT goes to COUNT_ACK, and WDATA goes to WDATA_ACK.
- Each acknowledge state leaves at the next falling edge:
  - ADDR_ACK goes to INDEX for a write and to TX for a read.
  - INDEX_ACK goes to COUNT.
  - COUNT_ACK and WDATA_ACK go to WDATA.
- TX goes to TX_ACK after eight bits. TX_ACK goes to TX_HOLD on a host acknowledge and to IGNORE on a not-acknowledge. TX_HOLD returns to TX at the next falling edge with the next byte loaded.

Top module: `smb_blk_regs`

## Requirements
- R1: After reset SDA is released (sda_oe = 0), every register reads 0x00 except the count register at index 8, which reads 0x04.
- R2: The address byte 0xD2 (device address 0x69, write bit 0 in the LSB) and 0xD3 (read bit 1) are acknowledged. Any other address byte gets no acknowledge, and every following byte gets none either until the next start.
- R3: In a write the first byte after the address sets the index and the second is the byte count. Data bytes are stored at index N, N+1, … in order, and the index, count and each data byte are acknowledged.
- R4: Only the first X data bytes of a write are stored, where X is the count byte. Further data bytes are acknowledged but leave all registers unchanged, and a count of 0 stores nothing.
- R5: A data byte whose index is 16 or above is acknowledged and changes no register.
- R6: In a read the slave sends the value of the register at index 8 first, then registers N, N+1, …, each MSB first. Index 8 is writable like any other register.
- R7: A read byte whose index is 16 or above is sent as 0x00.
- R8: After the host answers a read byte with a not-acknowledge, the slave keeps SDA released for all further clocks until the next start.
- R9: A stop or start detected part-way through a byte abandons that byte: a stop leaves the registers unchanged, and a repeated start begins a new address phase that keeps the current index.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: regs_o carries register i on bits 8i+7 down to 8i at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1 the pad pulls SDA low, when 0 SDA is released |
| regs_o | output | 128 | Parallel image of the 16-byte register file |

## Verification
Two things coincide at the falling SCL edge that closes a data byte: the byte is committed to the file, and the remaining count reaches zero or the index crosses the end of the file. Writes whose count equals the number of bytes sent plus one extra byte, and writes that start at index 14 and run past 15, provoke this cycle. The bench judges it by comparing the parallel register image with its own array on every clock while SCL is high. A start condition meeting an unfinished byte is provoked by cutting bytes short with a stop and with a repeated start. The check that follows is that no register moved and that the next read begins at the retained index.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_HOLD,
        ST_IGNORE
    } smb_st_e;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic            scl_p;
    logic            sda_p;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_p     = scl_pipe[STAGES];
    assign sda_p     = sda_pipe[STAGES];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int             DEPTH   = 16,
    parameter int             DW      = 8,
    parameter int             AW      = 8,
    parameter int             CNT_IDX = 8,
    parameter logic [DW-1:0]  CNT_RST = 'h04
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [DW-1:0]       wdata,
    input  logic [AW-1:0]       raddr,
    output logic [DW-1:0]       rdata,
    output logic [DW-1:0]       cnt_o,
    output logic [DEPTH*DW-1:0] flat_o
);

    localparam int            IW      = $clog2(DEPTH);
    localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (i == CNT_IDX) ? CNT_RST : '0;
            end
        end else if (we && (waddr < DEPTH_A)) begin
            mem[waddr[IW-1:0]] <= wdata;
        end
    end

    assign rdata = (raddr < DEPTH_A) ? mem[raddr[IW-1:0]] : '0;
    assign cnt_o = mem[CNT_IDX];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign flat_o[g*DW +: DW] = mem[g];
        end
    endgenerate

    // R5: a write aimed beyond the file leaves every register as it was
    p_past_end_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (waddr >= DEPTH_A)) |=> $stable(flat_o));

    // R11: the parallel image moves only when a write strobe was given
    p_image_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flat_o));

endmodule

// File: rtl/smb_blk_regs.sv
module smb_blk_regs
    import smb_blk_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         CNT_IDX  = 8,
    parameter logic [7:0] CNT_RST  = 8'h04,
    parameter int         SYNC     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [DEPTH*8-1:0] regs_o
);

    localparam int DW     = 8;
    localparam int PTR_W  = 8;
    localparam int BCNT_W = $clog2(DW) + 1;
    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DW);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    smb_line_sync #(.STAGES(SYNC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_st_e           st_q, st_d;
    logic [BCNT_W-1:0] bit_q, bit_d;
    logic [DW-1:0]     sh_q, sh_d;
    logic [DW-1:0]     tx_q, tx_d;
    logic [PTR_W-1:0]  ptr_q, ptr_d;
    logic [DW-1:0]     rem_q, rem_d;
    logic              oe_q, oe_d;
    logic              we;
    logic [DW-1:0]     rdata;
    logic [DW-1:0]     cnt_val;

    smb_regfile #(
        .DEPTH   (DEPTH),
        .DW      (DW),
        .AW      (PTR_W),
        .CNT_IDX (CNT_IDX),
        .CNT_RST (CNT_RST)
    ) u_file (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .waddr  (ptr_q),
        .wdata  (sh_q),
        .raddr  (ptr_q),
        .rdata  (rdata),
        .cnt_o  (cnt_val),
        .flat_o (regs_o)
    );

    // next state and datapath
    always_comb begin
        st_d  = st_q;
        bit_d = bit_q;
        sh_d  = sh_q;
        tx_d  = tx_q;
        ptr_d = ptr_q;
        rem_d = rem_q;
        oe_d  = oe_q;
        we    = 1'b0;
        if (stop_det) begin
            st_d  = ST_IDLE;
            oe_d  = 1'b0;
            bit_d = '0;
        end else if (start_det) begin
            st_d  = ST_ADDR;
            oe_d  = 1'b0;
            bit_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_IGNORE: begin
                    oe_d = 1'b0;
                end
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && (bit_q != LAST_BIT)) begin
                        sh_d  = {sh_q[DW-2:0], sda_s};
                        bit_d = bit_q + 1'b1;
                    end else if (scl_fall && (bit_q == LAST_BIT)) begin
                        bit_d = '0;
                        if (st_q == ST_ADDR) begin
                            if (sh_q[DW-1:1] == DEV_ADDR) begin
                                oe_d = 1'b1;
                                st_d = ST_ADDR_ACK;
                            end else begin
                                st_d = ST_IGNORE;
                            end
                        end else if (st_q == ST_INDEX) begin
                            ptr_d = sh_q;
                            oe_d  = 1'b1;
                            st_d  = ST_INDEX_ACK;
                        end else if (st_q == ST_COUNT) begin
                            rem_d = sh_q;
                            oe_d  = 1'b1;
                            st_d  = ST_COUNT_ACK;
                        end else begin
                            we    = (rem_q != '0);
                            if (rem_q != '0) rem_d = rem_q - 1'b1;
                            ptr_d = ptr_q + 1'b1;
                            oe_d  = 1'b1;
                            st_d  = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (sh_q[0]) begin
                            tx_d = cnt_val;
                            oe_d = ~cnt_val[DW-1];
                            st_d = ST_TX;
                        end else begin
                            oe_d = 1'b0;
                            st_d = ST_INDEX;
                        end
                    end
                end
                ST_INDEX_ACK: begin
                    if (scl_fall) begin
                        oe_d = 1'b0;
                        st_d = ST_COUNT;
                    end
                end
                ST_COUNT_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        oe_d = 1'b0;
                        st_d = ST_WDATA;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_d = bit_q + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_q == LAST_BIT) begin
                            oe_d  = 1'b0;
                            bit_d = '0;
                            st_d  = ST_TX_ACK;
                        end else begin
                            tx_d = {tx_q[DW-2:0], 1'b0};
                            oe_d = ~tx_q[DW-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        st_d = sda_s ? ST_IGNORE : ST_TX_HOLD;
                    end
                end
                ST_TX_HOLD: begin
                    if (scl_fall) begin
                        tx_d  = rdata;
                        oe_d  = ~rdata[DW-1];
                        ptr_d = ptr_q + 1'b1;
                        st_d  = ST_TX;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                    oe_d = 1'b0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q <= '0;
            sh_q  <= '0;
            tx_q  <= '0;
            ptr_q <= '0;
            rem_q <= '0;
            oe_q  <= 1'b0;
        end else begin
            bit_q <= bit_d;
            sh_q  <= sh_d;
            tx_q  <= tx_d;
            ptr_q <= ptr_d;
            rem_q <= rem_d;
            oe_q  <= oe_d;
        end
    end

    assign sda_oe = oe_q;

    // R10: the drive enable only moves after SCL was seen low
    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> !$past(scl_s));

    // R2 / R8: once ignoring, the slave never pulls SDA
    p_ignore_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IGNORE) |=> !oe_q);

    // R4: every stored data byte consumes one unit of the count
    p_count_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rem_q == $past(rem_q) - 1'b1));

    // R9: the bit counter never runs past one full byte
    p_bit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= LAST_BIT);

endmodule

// File: tb/tb_smb_blk_regs.sv
module tb_smb_blk_regs;

    localparam int DEPTH = 16;
    localparam int H     = 8;

    logic               clk   = 1'b0;
    logic               rst_n = 1'b0;
    logic               scl   = 1'b1;
    logic               sda_h = 1'b1;
    logic               sda_oe;
    logic [DEPTH*8-1:0] regs_o;
    logic               sda_line;

    assign sda_line = sda_h & ~sda_oe;

    always #10 clk = ~clk;

    smb_blk_regs dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .regs_o (regs_o)
    );

    int    n_cmp  = 0;
    int    n_bad  = 0;
    logic  [7:0] model [DEPTH];
    logic  exp_oe = 1'b0;
    string cur_req = "R1";
    bit    mon_en  = 1'b0;
    bit    done    = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [DEPTH*8-1:0] act, input logic [DEPTH*8-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DEPTH*8-1:0] model_flat();
        logic [DEPTH*8-1:0] f;
        for (int i = 0; i < DEPTH; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    // per-clock reference comparison while SCL is high (R10, R11)
    always @(posedge clk) begin
        #5;
        if (mon_en && scl) begin
            chk("R11", "register image", regs_o, model_flat());
            chk(cur_req, "sda drive R10", {{(DEPTH*8-1){1'b0}}, sda_oe},
                {{(DEPTH*8-1){1'b0}}, exp_oe});
        end
    end

    task automatic hp(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic h_start();
        exp_oe = 1'b0;
        sda_h = 1'b1; hp(H);
        scl = 1'b1;   hp(H);
        sda_h = 1'b0; hp(H);
        scl = 1'b0;   hp(H);
    endtask

    task automatic h_stop();
        exp_oe = 1'b0;
        sda_h = 1'b0; hp(H);
        scl = 1'b1;   hp(H);
        sda_h = 1'b1; hp(H);
    endtask

    task automatic h_bits(input logic [7:0] b, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sda_h = b[7-i]; exp_oe = 1'b0; hp(H);
            scl = 1'b1; hp(H);
            scl = 1'b0;
        end
    endtask

    // host writes one byte; widx is the model index it lands on (-1: none)
    task automatic hb_write(input logic [7:0] b, input bit exp_ack,
                            input int widx, input string req);
        cur_req = req;
        h_bits(b, 8);
        sda_h = 1'b1; hp(H);
        if (widx >= 0 && widx < DEPTH) model[widx] = b;
        exp_oe = exp_ack;
        scl = 1'b1; hp(H);
        chk(req, "ack bit", {{(DEPTH*8-1){1'b0}}, sda_line},
            {{(DEPTH*8-1){1'b0}}, ~exp_ack});
        scl = 1'b0;
    endtask

    // host reads one byte, then answers with ack (1) or not-ack (0)
    task automatic hb_read(input logic [7:0] exp, input bit host_ack,
                           input bit slave_on, input string req);
        logic [7:0] got;
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            sda_h = 1'b1; hp(H);
            exp_oe = slave_on & ~exp[i];
            scl = 1'b1; hp(H);
            got[i] = sda_line;
            scl = 1'b0;
        end
        chk(req, "read byte", {{(DEPTH*8-8){1'b0}}, got}, {{(DEPTH*8-8){1'b0}}, exp});
        sda_h = ~host_ack; exp_oe = 1'b0; hp(H);
        scl = 1'b1; hp(H);
        scl = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        model[8] = 8'h04;
        hp(5);
        // R1: reset values and released SDA
        chk("R1", "reset image", regs_o, model_flat());
        chk("R1", "reset sda", {{(DEPTH*8-1){1'b0}}, sda_oe}, '0);
        rst_n = 1'b1;
        hp(5);
        mon_en = 1'b1;

        // R3: block write of three bytes from index 2
        h_start();
        hb_write(8'hD2, 1, -1, "R2");
        hb_write(8'h02, 1, -1, "R3");
        hb_write(8'h03, 1, -1, "R3");
        hb_write(8'hA1, 1, 2, "R3");
        hb_write(8'hB2, 1, 3, "R3");
        hb_write(8'hC3, 1, 4, "R3");
        h_stop();

        // R4: count of 2 with a third byte discarded
        h_start();
        hb_write(8'hD2, 1, -1, "R4");
        hb_write(8'h0A, 1, -1, "R4");
        hb_write(8'h02, 1, -1, "R4");
        hb_write(8'h11, 1, 10, "R4");
        hb_write(8'h22, 1, 11, "R4");
        hb_write(8'h33, 1, -1, "R4");
        h_stop();
        // R4: count of zero stores nothing
        h_start();
        hb_write(8'hD2, 1, -1, "R4");
        hb_write(8'h00, 1, -1, "R4");
        hb_write(8'h00, 1, -1, "R4");
        hb_write(8'h55, 1, -1, "R4");
        h_stop();

        // R5: run past the end of the file
        h_start();
        hb_write(8'hD2, 1, -1, "R5");
        hb_write(8'h0E, 1, -1, "R5");
        hb_write(8'h04, 1, -1, "R5");
        hb_write(8'h66, 1, 14, "R5");
        hb_write(8'h77, 1, 15, "R5");
        hb_write(8'h88, 1, -1, "R5");
        hb_write(8'h99, 1, -1, "R5");
        h_stop();
        h_start();
        hb_write(8'hD2, 1, -1, "R5");
        hb_write(8'h14, 1, -1, "R5");
        hb_write(8'h01, 1, -1, "R5");
        hb_write(8'h5A, 1, -1, "R5");
        h_stop();

        // R6: program the count register at index 8
        h_start();
        hb_write(8'hD2, 1, -1, "R6");
        hb_write(8'h08, 1, -1, "R6");
        hb_write(8'h01, 1, -1, "R6");
        hb_write(8'h05, 1, 8, "R6");
        h_stop();

        // R6 then R8: indexed read from 2, host declines, extra clocks silent
        h_start();
        hb_write(8'hD2, 1, -1, "R6");
        hb_write(8'h02, 1, -1, "R6");
        h_start();
        hb_write(8'hD3, 1, -1, "R6");
        hb_read(8'h05, 1, 1, "R6");
        hb_read(8'hA1, 1, 1, "R6");
        hb_read(8'hB2, 1, 1, "R6");
        hb_read(8'hC3, 0, 1, "R8");
        hb_read(8'hFF, 0, 0, "R8");
        h_stop();

        // R7: read crossing the end returns zeros
        h_start();
        hb_write(8'hD2, 1, -1, "R7");
        hb_write(8'h0E, 1, -1, "R7");
        h_start();
        hb_write(8'hD3, 1, -1, "R7");
        hb_read(8'h05, 1, 1, "R7");
        hb_read(8'h66, 1, 1, "R7");
        hb_read(8'h77, 1, 1, "R7");
        hb_read(8'h00, 1, 1, "R7");
        hb_read(8'h00, 0, 1, "R7");
        h_stop();

        // R2: foreign address, later bytes also unacknowledged
        h_start();
        hb_write(8'hA4, 0, -1, "R2");
        hb_write(8'h03, 0, -1, "R2");
        hb_write(8'h01, 0, -1, "R2");
        hb_write(8'hEE, 0, -1, "R2");
        h_stop();

        // R9: stop in the middle of a data byte
        h_start();
        hb_write(8'hD2, 1, -1, "R9");
        hb_write(8'h00, 1, -1, "R9");
        hb_write(8'h02, 1, -1, "R9");
        cur_req = "R9";
        h_bits(8'h99, 4);
        h_stop();
        // R9: a fresh write still works, leaving the index at 2
        h_start();
        hb_write(8'hD2, 1, -1, "R9");
        hb_write(8'h01, 1, -1, "R9");
        hb_write(8'h01, 1, -1, "R9");
        hb_write(8'h42, 1, 1, "R9");
        h_stop();
        // R9: repeated start cuts an index byte short, index kept at 2
        h_start();
        hb_write(8'hD2, 1, -1, "R9");
        cur_req = "R9";
        h_bits(8'h0C, 3);
        h_start();
        hb_write(8'hD3, 1, -1, "R9");
        hb_read(8'h05, 1, 1, "R9");
        hb_read(8'hA1, 0, 1, "R9");
        h_stop();

        hp(20);
        mon_en = 1'b0;
        // R11: final image against the model
        chk("R11", "final image", regs_o, model_flat());
        finish_run();
    end

endmodule